// File: doc/BRIEF.md
# Two-Wire Serial Slave Register Port

This block is a slave-only two-wire serial interface (I2C protocol, 7-bit addressing) that gives an external host read and write access to a small file of 8-bit registers. The bus lines are brought into the system clock domain through synchronizer stages. The block then finds START and STOP conditions, shifts in bytes on rising serial clock edges, and answers with acknowledge bits and read data. It only ever pulls the data line low and never drives the clock line.

A write transaction carries the device address byte, then a register sub-address, then any number of data bytes. Each data byte lands at the current pointer, and the pointer then steps to the next register. A read transaction returns bytes from the current pointer, which also steps after every byte, until the host answers a byte with a not-acknowledge. An address-select pin chooses between two fixed device addresses. Only one of them is answered at a time.

Top module: `i2cp_top`

## Requirements
- R1: After reset the data pull-down output is inactive (0) and every register reads as 0x00.
- R2: A START (data falls while clock is high) begins a new address phase from any state, including a repeated START in the middle of a transfer. A STOP (data rises while clock is high) returns the block to idle with the data line released.
- R3: The data pull-down output only changes while the serial clock is low. Incoming data is sampled on the rising clock edge.
- R4: The first byte after START is sent MSB first as a 7-bit device address followed by a direction bit (1 = read, 0 = write). With select 0 the block answers address 0x20 (bytes 0x40/0x41), and with select 1 it answers 0x21 (bytes 0x42/0x43). It acknowledges by pulling data low for the whole ninth clock.
- R5: For an address byte that does not match, the block gives no acknowledge and ignores the bus until the next START. No register changes.
- R6: In a write, the byte after the address is the sub-address; only its low 4 bits select one of 16 registers. Each following data byte is acknowledged, stored at the pointer, and then the pointer increments, so multi-byte writes fill consecutive registers.
- R7: The register pointer wraps from 15 to 0 in both writes and reads.
- R8: In a read, bytes are sent MSB first starting at the current pointer, which increments after each byte. The read continues while the host acknowledges and ends on a not-acknowledge, after which the data line stays released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| addr_sel_i | input | 1 | Chooses which of the two device addresses is answered |
| sda_pull_o | output | 1 | 1 pulls the data line low (open-drain style), 0 releases it |

## Verification
A wrong pointer or a lost byte-counter position shows up at the ports within one transaction. Read data comes back from the wrong register or shifted by a bit, or the acknowledge appears in the wrong clock slot and the host sees a not-acknowledge. A mistaken state after a not-acknowledge or a non-matching address shows up as the data line being held low on the following clocks, before the next START. Registers that were meant to stay untouched are read back through the bus after each disturbing stimulus, so a stray write surfaces on the very next read.

// File: rtl/i2cp_pkg.sv
package i2cp_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_SUB,
      ST_SUB_ACK,
      ST_WDATA,
      ST_WDATA_ACK,
      ST_RDATA,
      ST_RDATA_ACK
   } port_state_t;

   localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/i2cp_sync.sv
module i2cp_sync #(
   parameter int unsigned WIDTH   = 2,
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("i2cp_sync: STAGES must be at least 2");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL}};
         else        chain <= {chain[STAGES-2:0], d_i[b]};
      end
      assign q_o[b] = chain[STAGES-1];
   end
endmodule

// File: rtl/i2cp_regfile.sv
module i2cp_regfile #(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                      mem[i] <= '0;
         else if (wr_en_i && (addr_i == ADDR_W'(i)))      mem[i] <= wdata_i;
      end
   end

   assign rdata_o = mem[addr_i];

   // R6: a write lands at the addressed word
   p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |=> mem[$past(addr_i)] == $past(wdata_i));
endmodule

// File: rtl/i2cp_ctrl.sv
module i2cp_ctrl
   import i2cp_pkg::*;
#(
   parameter int unsigned  PTR_W     = 4,
   parameter logic [6:0]   DEV_ADDR0 = 7'h20,
   parameter logic [6:0]   DEV_ADDR1 = 7'h21
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                scl_s_i,
   input  logic                sda_s_i,
   input  logic                addr_sel_i,
   input  logic [BYTE_W-1:0]   rd_data_i,
   output logic                wr_en_o,
   output logic [PTR_W-1:0]    ptr_o,
   output logic [BYTE_W-1:0]   wr_data_o,
   output logic                sda_pull_o
);
   localparam int unsigned CNT_W = 4;

   port_state_t       state;
   logic              scl_q, sda_q;
   logic [CNT_W-1:0]  cnt;
   logic [6:0]        shift;
   logic [7:0]        tx;
   logic              rw, ack_ph, ack_ok, pull;
   logic [PTR_W-1:0]  ptr;

   logic scl_rise, scl_fall, start_c, stop_c, byte_end;
   logic [7:0] byte_in;
   logic [6:0] dev_addr;

   assign scl_rise = scl_s_i & ~scl_q;
   assign scl_fall = ~scl_s_i & scl_q;
   assign start_c  = scl_s_i & scl_q & sda_q & ~sda_s_i;
   assign stop_c   = scl_s_i & scl_q & ~sda_q & sda_s_i;
   assign byte_in  = {shift, sda_s_i};
   assign byte_end = scl_rise && (cnt == CNT_W'(7));
   assign dev_addr = addr_sel_i ? DEV_ADDR1 : DEV_ADDR0;

   assign wr_en_o    = (state == ST_WDATA) && byte_end;
   assign wr_data_o  = byte_in;
   assign ptr_o      = ptr;
   assign sda_pull_o = pull;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s_i;
         sda_q <= sda_s_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         shift  <= '0;
         tx     <= '0;
         rw     <= 1'b0;
         ack_ph <= 1'b0;
         ack_ok <= 1'b0;
         pull   <= 1'b0;
         ptr    <= '0;
      end else if (start_c) begin
         state  <= ST_ADDR;
         cnt    <= '0;
         ack_ph <= 1'b0;
         pull   <= 1'b0;
      end else if (stop_c) begin
         state  <= ST_IDLE;
         ack_ph <= 1'b0;
         pull   <= 1'b0;
      end else begin
         unique case (state)
            ST_ADDR, ST_SUB, ST_WDATA: begin
               if (scl_rise) begin
                  shift <= byte_in[6:0];
                  cnt   <= cnt + 1'b1;
               end
               if (byte_end) begin
                  cnt <= '0;
                  if (state == ST_ADDR) begin
                     if (byte_in[7:1] == dev_addr) begin
                        rw    <= byte_in[0];
                        state <= ST_ADDR_ACK;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end else if (state == ST_SUB) begin
                     ptr   <= byte_in[PTR_W-1:0];
                     state <= ST_SUB_ACK;
                  end else begin
                     ptr   <= ptr + 1'b1;
                     state <= ST_WDATA_ACK;
                  end
               end
            end
            ST_ADDR_ACK, ST_SUB_ACK, ST_WDATA_ACK: begin
               if (scl_fall) begin
                  if (!ack_ph) begin
                     pull   <= 1'b1;
                     ack_ph <= 1'b1;
                  end else begin
                     ack_ph <= 1'b0;
                     cnt    <= '0;
                     if (state == ST_ADDR_ACK && rw) begin
                        state <= ST_RDATA;
                        tx    <= rd_data_i;
                        pull  <= ~rd_data_i[7];
                     end else begin
                        state <= (state == ST_ADDR_ACK) ? ST_SUB : ST_WDATA;
                        pull  <= 1'b0;
                     end
                  end
               end
            end
            ST_RDATA: begin
               if (scl_rise) cnt <= cnt + 1'b1;
               if (scl_fall) begin
                  if (cnt == CNT_W'(8)) begin
                     pull  <= 1'b0;
                     ptr   <= ptr + 1'b1;
                     state <= ST_RDATA_ACK;
                  end else if (cnt != '0) begin
                     pull <= ~tx[6];
                     tx   <= {tx[6:0], 1'b0};
                  end
               end
            end
            ST_RDATA_ACK: begin
               if (scl_rise) ack_ok <= ~sda_s_i;
               if (scl_fall) begin
                  if (ack_ok) begin
                     state <= ST_RDATA;
                     cnt   <= '0;
                     tx    <= rd_data_i;
                     pull  <= ~rd_data_i[7];
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            default: begin
               pull <= 1'b0;
            end
         endcase
      end
   end

   // R3: the pull-down only moves while the serial clock is low
   p_pull_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pull) |-> !scl_s_i);

   // R5 / R8: an idle block never holds the data line
   p_idle_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !pull);

   // R2: after a STOP the bus is released and the block idles
   p_stop_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
      stop_c |=> (!pull && state == ST_IDLE));

   // R6: each stored byte advances the pointer by one (R7: modulo wrap)
   p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |=> ptr == PTR_W'($past(ptr) + 1'b1));
endmodule

// File: rtl/i2cp_top.sv
module i2cp_top #(
   parameter int unsigned REG_AW      = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [6:0]  DEV_ADDR0   = 7'h20,
   parameter logic [6:0]  DEV_ADDR1   = 7'h21
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   input  logic addr_sel_i,
   output logic sda_pull_o
);
   import i2cp_pkg::*;

   if (REG_AW < 1 || REG_AW > 8) begin : g_bad_aw
      $error("i2cp_top: REG_AW must be within 1..8");
   end
   if (DEV_ADDR0 == DEV_ADDR1) begin : g_bad_addr
      $error("i2cp_top: the two device addresses must differ");
   end

   logic [1:0]        bus_s;
   logic              wr_en;
   logic [REG_AW-1:0] ptr;
   logic [BYTE_W-1:0] wdata, rdata;

   i2cp_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({scl_i, sda_i}),
      .q_o   (bus_s)
   );

   i2cp_ctrl #(.PTR_W(REG_AW), .DEV_ADDR0(DEV_ADDR0), .DEV_ADDR1(DEV_ADDR1)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_s_i    (bus_s[1]),
      .sda_s_i    (bus_s[0]),
      .addr_sel_i (addr_sel_i),
      .rd_data_i  (rdata),
      .wr_en_o    (wr_en),
      .ptr_o      (ptr),
      .wr_data_o  (wdata),
      .sda_pull_o (sda_pull_o)
   );

   i2cp_regfile #(.ADDR_W(REG_AW), .DATA_W(BYTE_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en_i (wr_en),
      .addr_i  (ptr),
      .wdata_i (wdata),
      .rdata_o (rdata)
   );
endmodule

// File: tb/i2cp_top_tb.sv
module i2cp_top_tb_top;
   localparam int Q = 8;

   typedef struct {
      logic [7:0] val;
      string      req;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sel = 1'b0;
   logic sda_pull;
   wire  sda_bus = sda_m & ~sda_pull;

   int errors = 0;
   int checks = 0;
   int r3_viol = 0;
   exp_t       exp_q[$];
   logic [7:0] obs_q[$];

   always #5 clk = ~clk;

   i2cp_top dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_m),
      .sda_i      (sda_bus),
      .addr_sel_i (sel),
      .sda_pull_o (sda_pull)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bit_out(input logic b);
      sda_m = b; wq();
      scl_m = 1'b1; wq(); wq();
      scl_m = 1'b0; wq();
   endtask

   task automatic bit_in(output logic b);
      sda_m = 1'b1; wq();
      scl_m = 1'b1; wq();
      b = sda_bus; wq();
      scl_m = 1'b0; wq();
   endtask

   task automatic do_start();
      sda_m = 1'b1; wq();
      scl_m = 1'b1; wq();
      sda_m = 1'b0; wq();
      scl_m = 1'b0; wq();
   endtask

   task automatic do_stop();
      sda_m = 1'b0; wq();
      scl_m = 1'b1; wq();
      sda_m = 1'b1; wq();
   endtask

   task automatic send(input logic [7:0] d, input logic exp_ack, input string req);
      logic a;
      for (int i = 7; i >= 0; i--) bit_out(d[i]);
      bit_in(a);
      chk((a == 1'b0) == exp_ack, req, {31'd0, ~a}, {31'd0, exp_ack});
   endtask

   task automatic recv(input logic ack, input logic [7:0] expv, input string req);
      logic [7:0] d;
      exp_q.push_back('{val: expv, req: req});
      for (int i = 7; i >= 0; i--) bit_in(d[i]);
      bit_out(~ack);
      obs_q.push_back(d);
   endtask

   // scoreboard monitor
   initial begin
      forever begin
         @(negedge clk);
         while (obs_q.size() > 0 && exp_q.size() > 0) begin
            automatic logic [7:0] o = obs_q.pop_front();
            automatic exp_t e = exp_q.pop_front();
            chk(o == e.val, e.req, o, e.val);
         end
      end
   end

   // R3 observer: pull-down must not move while the bus clock is high
   logic pull_q = 1'b0;
   always @(negedge clk) begin
      if (rst_n && sda_pull != pull_q && scl_m) r3_viol++;
      pull_q <= sda_pull;
   end

   task automatic run();
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(sda_pull == 1'b0, "R1 released after reset", sda_pull, 0);

      // R1: default register value read from 0
      do_start(); send(8'h41, 1'b1, "R4 read address ack");
      recv(1'b0, 8'h00, "R1 default register");
      repeat (4) @(negedge clk);
      chk(sda_pull == 1'b0, "R8 released after NACK", sda_pull, 0);
      do_stop();

      // R6: multi-byte write to 3,4,5
      do_start(); send(8'h40, 1'b1, "R4 write address ack sel0");
      send(8'h03, 1'b1, "R6 sub-address ack");
      send(8'hA1, 1'b1, "R6 data ack 1");
      send(8'hB2, 1'b1, "R6 data ack 2");
      send(8'hC3, 1'b1, "R6 data ack 3");
      do_stop();
      repeat (4) @(negedge clk);
      chk(sda_pull == 1'b0, "R2 released after STOP", sda_pull, 0);

      // R8: read back with repeated start
      do_start(); send(8'h40, 1'b1, "R4 write address");
      send(8'h03, 1'b1, "R6 sub-address");
      do_start(); send(8'h41, 1'b1, "R2 repeated start read address");
      recv(1'b1, 8'hA1, "R8 read byte 1");
      recv(1'b1, 8'hB2, "R8 read byte 2");
      recv(1'b0, 8'hC3, "R8 read byte 3");
      do_stop();
      // pointer left at 6
      do_start(); send(8'h41, 1'b1, "R8 read address");
      recv(1'b0, 8'h00, "R8 pointer advanced to 6");
      do_stop();

      // R7: wrap 15 -> 0
      do_start(); send(8'h40, 1'b1, "R7 address");
      send(8'h0F, 1'b1, "R7 sub 15");
      send(8'h5A, 1'b1, "R7 data 15");
      send(8'h6B, 1'b1, "R7 data wraps to 0");
      do_start(); send(8'h40, 1'b1, "R7 address");
      send(8'h1F, 1'b1, "R6 sub-address upper bits ignored");
      do_start(); send(8'h41, 1'b1, "R7 read address");
      recv(1'b1, 8'h5A, "R7 read 15");
      recv(1'b0, 8'h6B, "R7 read wraps to 0");
      do_stop();

      // R5: non-matching address ignored
      do_start(); send(8'h42, 1'b0, "R5 no ack wrong address");
      send(8'h03, 1'b0, "R5 sub ignored");
      send(8'h99, 1'b0, "R5 data ignored");
      do_stop();
      do_start(); send(8'h40, 1'b1, "R5 address");
      send(8'h03, 1'b1, "R5 sub");
      do_start(); send(8'h41, 1'b1, "R5 read address");
      recv(1'b0, 8'hA1, "R5 register unchanged");
      do_stop();

      // R4: select 1
      sel = 1'b1;
      do_start(); send(8'h40, 1'b0, "R5 sel1 rejects 0x40");
      do_stop();
      do_start(); send(8'h42, 1'b1, "R4 sel1 accepts 0x42");
      send(8'h0A, 1'b1, "R6 sub 10");
      send(8'h22, 1'b1, "R6 data 10");
      do_stop();
      // R2: repeated START mid-write
      do_start(); send(8'h42, 1'b1, "R2 address");
      send(8'h09, 1'b1, "R2 sub 9");
      send(8'h11, 1'b1, "R2 data 9");
      do_start(); send(8'h43, 1'b1, "R2 repeated start read");
      recv(1'b1, 8'h22, "R2 read continues at 10");
      recv(1'b0, 8'h00, "R8 next register 11");
      do_stop();
      do_start(); send(8'h42, 1'b1, "R6 address");
      send(8'h09, 1'b1, "R6 sub 9");
      do_start(); send(8'h43, 1'b1, "R6 read address");
      recv(1'b0, 8'h11, "R6 register 9 written");
      do_stop();
      repeat (10) @(negedge clk);
   endtask

   initial begin
      fork
         run();
         begin
            repeat (150000) @(negedge clk);
            checks++; errors++;
            $display("FAIL watchdog: actual=expired expected=done");
         end
      join_any
      disable fork;
      repeat (4) @(negedge clk);
      chk(r3_viol == 0, "R3 pull-down changed while SCL high", r3_viol, 0);
      chk(exp_q.size() == 0, "R8 scoreboard drained", exp_q.size(), 0);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule